// File: doc/BRIEF.md
# Multichannel DAC SPI Command Sequencer

This block writes to an eight-channel serial DAC over a write-only, four-wire serial link. Every register write goes out as one 24-bit frame, most significant bit first. The frame holds a write flag, then an address byte, then a 16-bit data word. SCLK idles low. SDI changes on SCLK rising edges and is sampled by the converter on falling edges. Chip select is held low with a programmable setup margin before the first clock and a programmable hold margin after the last falling edge. Between frames it stays high for a minimum gap.

The host can start two kinds of job. A one-cycle `start` pulse runs a fixed five-frame initialisation:
1. Write the gain/divider register.
2. Mark the even channels for broadcast.
3. Broadcast code A.
4. Re-mark the odd channels.
5. Broadcast code B.

A single-channel write goes in over a valid/ready request port. It carries a channel index and a code and sends exactly one frame. The request transfers on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while no job is running and `start` is low. A host that holds `wr_valid` waits for the block to become free. A request pulsed while the block is busy never transfers and is dropped. `busy` covers a whole job, including the closing chip-select gap. `done` marks the end of each job.

Top module: `dac_spi_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `busy` and `done` are 0. `wr_ready` is 1 while `start` is low.
- R2: Each frame has exactly 24 SCLK falling edges while `cs_n` is low. SDI at those edges, MSB first, forms a word with bit 23 = 0 (write). Bits 22:16 hold the register address and bits 15:0 hold the data.
- R3: SCLK is low whenever `cs_n` is high. While `cs_n` is low, SDI changes only in the cycle where SCLK rises. The first bit is already on SDI when `cs_n` falls.
- R4: SCLK rising edges inside a frame are DIV system clocks apart, and SCLK stays high for DIV/2 clocks.
- R5: The first SCLK rising edge comes exactly CSU clocks after `cs_n` falls. `cs_n` rises exactly CHD clocks after the 24th falling edge.
- R6: Between two frames `cs_n` stays high for at least GAP clocks.
- R7: A single-channel request for channel n with code c sends the one frame {0, 8+n, c}, where channel 0's data register is at address 0x08.
- R8: A `start` pulse sends exactly five frames, in this order:
  1. The gain word (address 0x04).
  2. 0x0255FF (channels 0, 2, 4, 6 marked).
  3. {0x06, code A}.
  4. 0x02AAFF (channels 1, 3, 5, 7 marked).
  5. {0x06, code B}.
- R9: The gain word's data is {7'b0, `ref_div`, 8 copies of `gain_x2`}. So `ref_div`=0 with `gain_x2`=1 gives 0x0400FF, and `ref_div`=1 with `gain_x2`=0 gives 0x040100.
- R10: `done` is high for exactly one cycle, one clock after `cs_n` rises at the end of a job's last frame, and `busy` is still high in that cycle. A job yields exactly one `done`.
- R11: While `busy` is high, `wr_ready` is 0, and `start` and `wr_valid` pulses have no effect. Codes and gain settings are captured when the job is accepted, so later input changes do not alter its frames.
- R12: When `start` and `wr_valid` are both high in an idle cycle, `start` wins and the request does not transfer.
- R13: A job sends no frames beyond its own. Afterwards `cs_n` stays high until the next accepted job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the broadcast start-up job |
| code_a | input | 16 | Code broadcast to the even channels |
| code_b | input | 16 | Code broadcast to the odd channels |
| gain_x2 | input | 1 | Selects output gain x2 for all channels in the gain word |
| ref_div | input | 1 | Selects reference divide-by-2 in the gain word |
| wr_valid | input | 1 | Single-channel write request valid |
| wr_ready | output | 1 | Block can take a request this cycle |
| wr_chan | input | 3 | Channel index of the request |
| wr_code | input | 16 | Code of the request |
| sclk | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data, changes on SCLK rise |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A corrupted shift register or bit counter shows up within one frame. The decoded word changes, or the number of falling edges before `cs_n` rises is not 24. A timing counter that loads the wrong value moves an SCLK edge or the chip-select edge by whole clocks. That is measured on the first affected edge. A wrong step counter or a wrong job flag shows in the order or count of frames within the job. A lost last-frame test shows as a missing, doubled or early `done`, or as frames appearing after the job should have ended.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int NCH     = 8;
  localparam int CH_W    = $clog2(NCH);
  localparam int STEPS   = 5;

  localparam logic [ADDR_W-1:0] ADDR_GAIN  = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_GROUP = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_BCAST = 7'h06;
  localparam logic [ADDR_W-1:0] ADDR_CH0   = 7'h08;

  typedef enum logic [2:0] {
    TX_IDLE, TX_SETUP, TX_HIGH, TX_LOW, TX_HOLD, TX_GAP
  } tx_state_e;

  typedef enum logic [1:0] {
    JOB_IDLE, JOB_LOAD, JOB_WAIT
  } job_state_e;

  function automatic logic [FRAME_W-1:0] pack_write(input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] data);
    return {1'b0, addr, data};
  endfunction
endpackage

// File: rtl/dac_seq_spi_tx.sv
module dac_seq_spi_tx
  import dac_seq_pkg::*;
#(
  parameter int DIV = 10,
  parameter int CSU = 5,
  parameter int CHD = 5,
  parameter int GAP = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  output logic               idle,
  output logic               cs_rise,
  output logic               fend,
  output logic               sclk,
  output logic               sdi,
  output logic               cs_n
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = $clog2(DIV + CSU + CHD + GAP + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  tx_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] shreg;

  assign idle = (st == TX_IDLE);
  assign sdi  = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      cs_rise <= 1'b0;
      fend    <= 1'b0;
    end else begin
      cs_rise <= 1'b0;
      fend    <= 1'b0;
      unique case (st)
        TX_IDLE: if (go) begin
          shreg <= frame;
          cs_n  <= 1'b0;
          cnt   <= CNT_W'(CSU - 1);
          bitn  <= BIT_W'(FRAME_W - 1);
          st    <= TX_SETUP;
        end
        TX_SETUP: if (cnt == '0) begin
          sclk <= 1'b1;
          cnt  <= CNT_W'(HALF - 1);
          st   <= TX_HIGH;
        end else cnt <= cnt - 1'b1;
        TX_HIGH: if (cnt == '0) begin
          sclk <= 1'b0;
          if (bitn == '0) begin
            cnt <= CNT_W'(CHD - 1);
            st  <= TX_HOLD;
          end else begin
            cnt <= CNT_W'(HALF - 1);
            st  <= TX_LOW;
          end
        end else cnt <= cnt - 1'b1;
        TX_LOW: if (cnt == '0) begin
          sclk  <= 1'b1;
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
          bitn  <= bitn - 1'b1;
          cnt   <= CNT_W'(HALF - 1);
          st    <= TX_HIGH;
        end else cnt <= cnt - 1'b1;
        TX_HOLD: if (cnt == '0) begin
          cs_n    <= 1'b1;
          cs_rise <= 1'b1;
          shreg   <= '0;
          cnt     <= CNT_W'(GAP - 1);
          st      <= TX_GAP;
        end else cnt <= cnt - 1'b1;
        TX_GAP: if (cnt == '0) begin
          st   <= TX_IDLE;
          fend <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R3
  sdi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdi));

  // R5
  cs_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DATA_W-1:0]  code_a,
  input  logic [DATA_W-1:0]  code_b,
  input  logic               gain_x2,
  input  logic               ref_div,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [CH_W-1:0]    wr_chan,
  input  logic [DATA_W-1:0]  wr_code,
  input  logic               tx_idle,
  input  logic               tx_cs_rise,
  input  logic               tx_fend,
  output logic               tx_go,
  output logic [FRAME_W-1:0] tx_frame,
  output logic               busy,
  output logic               done
);
  localparam int STEP_W = $clog2(STEPS);

  job_state_e         st;
  logic [STEP_W-1:0]  step;
  logic               is_seq;
  logic [DATA_W-1:0]  a_q, b_q;
  logic               gx2_q, div_q;
  logic [FRAME_W-1:0] single_q;
  logic [FRAME_W-1:0] seq_frame;
  logic [NCH-1:0]     even_mask, odd_mask;
  logic               last;
  logic               take_start;

  for (genvar g = 0; g < NCH; g++) begin : g_mask
    assign even_mask[g] = ((g % 2) == 0);
    assign odd_mask[g]  = ((g % 2) == 1);
  end

  assign take_start = (st == JOB_IDLE) && start;
  assign wr_ready   = (st == JOB_IDLE) && !start;
  assign busy       = (st != JOB_IDLE);
  assign tx_go      = (st == JOB_LOAD);
  assign last       = !is_seq || (step == STEP_W'(STEPS - 1));

  always_comb begin
    unique case (step)
      3'd0:    seq_frame = pack_write(ADDR_GAIN, {7'b0, div_q, {8{gx2_q}}});
      3'd1:    seq_frame = pack_write(ADDR_GROUP, {even_mask, 8'hFF});
      3'd2:    seq_frame = pack_write(ADDR_BCAST, a_q);
      3'd3:    seq_frame = pack_write(ADDR_GROUP, {odd_mask, 8'hFF});
      default: seq_frame = pack_write(ADDR_BCAST, b_q);
    endcase
  end

  assign tx_frame = is_seq ? seq_frame : single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= JOB_IDLE;
      step     <= '0;
      is_seq   <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      gx2_q    <= 1'b0;
      div_q    <= 1'b0;
      single_q <= '0;
      done     <= 1'b0;
    end else begin
      done <= (st == JOB_WAIT) && tx_cs_rise && last;
      unique case (st)
        JOB_IDLE: begin
          if (take_start) begin
            a_q    <= code_a;
            b_q    <= code_b;
            gx2_q  <= gain_x2;
            div_q  <= ref_div;
            is_seq <= 1'b1;
            step   <= '0;
            st     <= JOB_LOAD;
          end else if (wr_valid && wr_ready) begin
            single_q <= pack_write(ADDR_CH0 + ADDR_W'(wr_chan), wr_code);
            is_seq   <= 1'b0;
            step     <= '0;
            st       <= JOB_LOAD;
          end
        end
        JOB_LOAD: st <= JOB_WAIT;
        JOB_WAIT: if (tx_fend) begin
          if (last) st <= JOB_IDLE;
          else begin
            step <= step + 1'b1;
            st   <= JOB_LOAD;
          end
        end
        default: st <= JOB_IDLE;
      endcase
    end
  end

  // R13
  go_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> tx_idle);

  // R10
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_inside_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R8
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_seq |-> (step <= STEP_W'(STEPS - 1)));
endmodule

// File: rtl/dac_spi_seq.sv
module dac_spi_seq
  import dac_seq_pkg::*;
#(
  parameter int DIV = 10,
  parameter int CSU = DIV / 2,
  parameter int CHD = DIV / 2,
  parameter int GAP = DIV
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] code_a,
  input  logic [15:0] code_b,
  input  logic        gain_x2,
  input  logic        ref_div,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [2:0]  wr_chan,
  input  logic [15:0] wr_code,
  output logic        sclk,
  output logic        sdi,
  output logic        cs_n,
  output logic        busy,
  output logic        done
);
  logic               tx_go, tx_idle, tx_cs_rise, tx_fend;
  logic [FRAME_W-1:0] tx_frame;

  dac_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code_a(code_a), .code_b(code_b),
    .gain_x2(gain_x2), .ref_div(ref_div),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_code(wr_code),
    .tx_idle(tx_idle), .tx_cs_rise(tx_cs_rise), .tx_fend(tx_fend),
    .tx_go(tx_go), .tx_frame(tx_frame),
    .busy(busy), .done(done)
  );

  dac_seq_spi_tx #(.DIV(DIV), .CSU(CSU), .CHD(CHD), .GAP(GAP)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(tx_go), .frame(tx_frame),
    .idle(tx_idle), .cs_rise(tx_cs_rise), .fend(tx_fend),
    .sclk(sclk), .sdi(sdi), .cs_n(cs_n)
  );
endmodule

// File: tb/dac_spi_seq_bench.sv
module dac_spi_seq_bench;
  localparam int DIV  = 8;
  localparam int CSU  = 3;
  localparam int CHD  = 2;
  localparam int GAP  = 8;
  localparam int HALF = DIV / 2;

  // {channel, code}
  localparam logic [18:0] WR_TAB [8] = '{
    {3'd0, 16'h0000}, {3'd7, 16'hFFFF}, {3'd3, 16'h8000}, {3'd5, 16'h1234},
    {3'd1, 16'hA5A5}, {3'd6, 16'h0001}, {3'd2, 16'h7FFF}, {3'd4, 16'hC3C3}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, gain_x2 = 1'b0, ref_div = 1'b0, wr_valid = 1'b0;
  logic [15:0] code_a = '0, code_b = '0, wr_code = '0;
  logic [2:0]  wr_chan = '0;
  logic        wr_ready, sclk, sdi, cs_n, busy, done;

  dac_spi_seq #(.DIV(DIV), .CSU(CSU), .CHD(CHD), .GAP(GAP)) u_dac_spi_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .code_a(code_a), .code_b(code_b),
    .gain_x2(gain_x2), .ref_div(ref_div), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_code(wr_code), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  int nchk = 0, nerr = 0;
  bit summary_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // port monitor, sampled on the falling clock edge
  int t = 0, t_csfall = 0, t_csrise = 0, t_rise = 0, t_fall = 0;
  int nbits = 0, nfr = 0, ndone = 0;
  bit first_rise = 1'b0, had_frame = 1'b0;
  logic [23:0] shin;
  logic [23:0] fr [64];
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    t++;
    if (rst_n) begin
      if (cs_n && sclk) chk(1'b0, "R3 sclk high while cs_n high", sclk, 0);
      if (!cs_n && p_cs) begin
        t_csfall = t; nbits = 0; first_rise = 1'b1; shin = '0;
        if (had_frame) chk(t - t_csrise >= GAP, "R6 cs_n high gap", t - t_csrise, GAP);
        chk(busy, "R10 busy during frame", busy, 1);
      end
      if (!cs_n && !p_cs && sdi != p_sdi && !(sclk && !p_sclk))
        chk(1'b0, "R3 sdi changed off rising edge", sdi, p_sdi);
      if (!cs_n && sclk && !p_sclk) begin
        if (first_rise) chk(t - t_csfall == CSU, "R5 cs setup", t - t_csfall, CSU);
        else            chk(t - t_rise == DIV, "R4 sclk period", t - t_rise, DIV);
        first_rise = 1'b0; t_rise = t;
      end
      if (!cs_n && !sclk && p_sclk) begin
        chk(t - t_rise == HALF, "R4 sclk high width", t - t_rise, HALF);
        shin = {shin[22:0], sdi}; nbits++; t_fall = t;
      end
      if (cs_n && !p_cs) begin
        chk(nbits == 24, "R2 bits per frame", nbits, 24);
        chk(t - t_fall == CHD, "R5 cs hold", t - t_fall, CHD);
        chk(shin[23] == 1'b0, "R2 write flag", shin[23], 0);
        if (nfr < 64) fr[nfr] = shin;
        nfr++; t_csrise = t; had_frame = 1'b1;
      end
      if (done) begin
        chk(!p_done, "R10 done one cycle", p_done, 0);
        chk(t - t_csrise == 1, "R10 done timing", t - t_csrise, 1);
        chk(busy, "R10 busy at done", busy, 1);
        ndone++;
      end
    end
    p_cs = cs_n; p_sclk = sclk; p_sdi = sdi; p_done = done;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic single_write(input logic [2:0] ch, input logic [15:0] code);
    @(posedge clk); #1;
    wr_chan = ch; wr_code = code; wr_valid = 1'b1;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_code = ~code;
    wait_idle();
  endtask

  task automatic check_seq(input int base, input logic [15:0] gword, input logic [15:0] a,
                           input logic [15:0] b, input string tag);
    chk(nfr == base + 5, {tag, " R8 frame count"}, nfr, base + 5);
    chk(fr[base]   == {8'h04, gword}, {tag, " R9 gain word"}, fr[base], {8'h04, gword});
    chk(fr[base+1] == 24'h0255FF,     {tag, " R8 even select"}, fr[base+1], 24'h0255FF);
    chk(fr[base+2] == {8'h06, a},     {tag, " R8 broadcast A"}, fr[base+2], {8'h06, a});
    chk(fr[base+3] == 24'h02AAFF,     {tag, " R8 odd select"}, fr[base+3], 24'h02AAFF);
    chk(fr[base+4] == {8'h06, b},     {tag, " R8 broadcast B"}, fr[base+4], {8'h06, b});
  endtask

  initial begin
    int base, dn;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset lines", {cs_n, sclk}, 2'b10);
    chk(!busy && !done && wr_ready, "R1 reset flags", {busy, done, wr_ready}, 3'b001);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && wr_ready, "R1 after release", {cs_n, busy, wr_ready}, 3'b101);

    // R7 R2 table of single writes
    foreach (WR_TAB[i]) begin
      base = nfr; dn = ndone;
      single_write(WR_TAB[i][18:16], WR_TAB[i][15:0]);
      chk(nfr == base + 1, "R7 one frame", nfr, base + 1);
      chk(fr[base] == {1'b0, 7'(8 + WR_TAB[i][18:16]), WR_TAB[i][15:0]}, "R7 frame value",
          fr[base], {1'b0, 7'(8 + WR_TAB[i][18:16]), WR_TAB[i][15:0]});
      chk(ndone == dn + 1, "R10 done per write", ndone, dn + 1);
    end

    // R8 R9 R11 start-up job; inputs change after capture, extra requests mid-job
    base = nfr; dn = ndone;
    @(posedge clk); #1;
    code_a = 16'h4000; code_b = 16'hC000; gain_x2 = 1'b1; ref_div = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; code_a = 16'h1111; code_b = 16'h2222; gain_x2 = 1'b0; ref_div = 1'b1;
    while (nfr < base + 1) @(negedge clk);
    @(posedge clk); #1;
    start = 1'b1; wr_valid = 1'b1; wr_chan = 3'd3; wr_code = 16'hDEAD;
    @(negedge clk);
    chk(!wr_ready, "R11 no ready while busy", wr_ready, 0);
    @(posedge clk); #1;
    start = 1'b0; wr_valid = 1'b0;
    wait_idle();
    check_seq(base, 16'h00FF, 16'h4000, 16'hC000, "job1");
    chk(ndone == dn + 1, "R10 one done per job", ndone, dn + 1);
    // R13 nothing more goes out
    repeat (400) @(negedge clk);
    chk(nfr == base + 5 && cs_n, "R13 quiet after job", nfr, base + 5);

    // R9 divider set, gain x1
    base = nfr;
    @(posedge clk); #1;
    code_a = 16'h0F0F; code_b = 16'hF0F0; gain_x2 = 1'b0; ref_div = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();
    check_seq(base, 16'h0100, 16'h0F0F, 16'hF0F0, "job2");

    // R12 start wins over a simultaneous request
    base = nfr;
    @(posedge clk); #1;
    code_a = 16'hABCD; code_b = 16'h0123; gain_x2 = 1'b1; ref_div = 1'b1;
    start = 1'b1; wr_valid = 1'b1; wr_chan = 3'd2; wr_code = 16'hBEEF;
    @(negedge clk);
    chk(!wr_ready, "R12 ready low with start", wr_ready, 0);
    @(posedge clk); #1;
    start = 1'b0; wr_valid = 1'b0;
    wait_idle();
    check_seq(base, 16'h01FF, 16'hABCD, 16'h0123, "job3");
    repeat (50) @(negedge clk);
    chk(nfr == base + 5, "R12 request not taken", nfr, base + 5);

    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", nfr);
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    end
    $finish;
  end
endmodule